// File: doc/BRIEF.md
# Serial-Access Control Register Bank with Latched Overload Flags

This block is a serial peripheral slave placed in front of a small bank of 8-bit control and status registers for a mixed-signal front end. A host transfers 16-bit frames, most significant bit first, while holding an active-low chip select. Each frame carries a read/write flag, a register address and one data byte. Writes update enable, gain and control registers, and these registers drive the analog blocks directly. Reads return the addressed byte during the second half of the same frame.

Two overload event inputs, one thermal and one current, feed latched status flags. Each flag is captured only while its enable bit is set. It stays set until the host writes a zero to it. Writing a three-bit key to the status register puts the enable, gain and interrupt-enable registers back to their power-on values.

The serial pins are brought into the system clock domain through a synchronizer with a parameterized number of stages. All register state is kept in that domain.

Top module: `spi_regbank`

## Requirements
- R1: A frame is 16 bits shifted MSB first while `spi_cs_n` is low. Frame bit 15 is the direction (1 = read, 0 = write), bits 13:8 are the register address, bit 14 is ignored, and bits 7:0 are the data. A write takes effect once the 16th rising SCLK edge has been sampled.
- R2: MOSI is sampled on rising SCLK edges, and MISO changes only after falling SCLK edges. In a read frame, MISO is 0 during the first 8 bits. The addressed byte is loaded after the 8th rising edge and is presented MSB first for the 9th to 16th rising edges.
- R3: After reset the registers read as follows: 0x01 = 0x00, 0x02 = 0x32, 0x03 = 0x00, 0x04 = 0x00, 0x05 = 0x01, 0x09 = 0x00, 0x0A = DIE_ID (default 0x00), 0x0B = REV_ID (default 0x02).
- R4: Output field layout:
  - `enable1_o` holds bits 5:0 of register 0x01 (bit 0 PA, bit 1 TX, bit 2 RX, bit 3 ERX, bit 4 ETX, bit 5 DAC).
  - `enable2_o` holds bits 3:0 of register 0x03 (bit 0 ZC, bit 1 REF1, bit 2 REF2, bit 3 PA output stage).
  - `gain_o` holds bits 5:0 of register 0x02 (RX PGA1 in 1:0, RX PGA2 in 3:2, TX PGA in 5:4).
  - `ctrl1_o` holds all 8 bits of register 0x04.
  - Reserved bits ignore writes and read as 0.
- R5: Writes to the identification registers (0x0A, 0x0B) and to unmapped addresses change nothing. Unmapped addresses read as 0x00.
- R6: Register 0x05 bit 5 enables thermal capture and bit 6 enables current capture. Bit 0 reads as a fixed 1. A flag (0x09 bit 5 thermal, bit 6 current) is set in the clock cycle after a one-cycle event pulse only if its enable bit is set.
- R7: A set flag stays set until a write to 0x09 carries a 0 in that flag's bit. Writing a 1 has no effect. An enabled event in the same cycle as a clearing write leaves the flag set.
- R8: A write to 0x09 with bits 4:2 equal to 3'b101 restores the reset values of registers 0x01, 0x02, 0x03 and 0x05. It leaves 0x04 and the flags untouched. Any other value in bits 4:2 restores nothing, and bits 4:2 always read as 0.
- R9: A frame in which chip select rises before the 16th rising SCLK edge changes no register. The next frame starts with a fresh bit count.
- R10: `spi_miso_oe` is low whenever `spi_cs_n` is high and high whenever it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad; pad floats when low |
| therm_evt | input | 1 | Thermal overload event pulse |
| curr_evt | input | 1 | Current overload event pulse |
| enable1_o | output | 6 | Block enables from register 0x01 |
| enable2_o | output | 4 | Block enables from register 0x03 |
| gain_o | output | 6 | Gain fields from register 0x02 |
| ctrl1_o | output | 8 | Control byte from register 0x04 |

## Verification
The bench builds the block with SYNC_STAGES = 3 and DIE_ID = 8'hC3, keeping REV_ID at its default. The deeper synchronizer stretches the delay from a falling SCLK edge to a valid MISO bit, so the bench exercises the read path with the smallest margin it uses. The nonzero die identifier makes the hard-wired read path and the ignored writes to it visible bit by bit. The SCLK half period is set at eight system clocks, which keeps every frame edge resolvable after three synchronizer stages.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  DIE_ID      = 8'h00,
  parameter logic [7:0]  REV_ID      = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic       therm_evt,
  input  logic       curr_evt,
  output logic [5:0] enable1_o,
  output logic [3:0] enable2_o,
  output logic [5:0] gain_o,
  output logic [7:0] ctrl1_o
);
  localparam int         TOP      = SYNC_STAGES - 1;
  localparam int         FRAME    = 16;
  localparam int         HALF     = FRAME / 2;
  localparam int         CW       = $clog2(FRAME + 1);
  localparam logic [5:0] GAIN_DEF = 6'h32;
  localparam logic [5:0] A_EN1 = 6'h01, A_GAIN = 6'h02, A_EN2 = 6'h03, A_CTL1 = 6'h04,
                         A_CTL2 = 6'h05, A_STAT = 6'h09, A_DIE = 6'h0A, A_REV = 6'h0B;

  logic [TOP:0]  sclk_q, cs_q, mosi_q;
  logic          sclk_d;
  logic          cs_s, mosi_s, rise, fall;
  logic [CW-1:0] cnt;
  logic [14:0]   sh;
  logic [7:0]    tx, rd_byte, wdata;
  logic [5:0]    waddr, raddr;
  logic          commit, wr, load;
  logic          ten, ien, tflag, iflag, clr_t, clr_i, srst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[TOP-1:0], spi_sclk};
      cs_q   <= {cs_q[TOP-1:0], spi_cs_n};
      mosi_q <= {mosi_q[TOP-1:0], spi_mosi};
      sclk_d <= sclk_q[TOP];
    end

  assign cs_s   = cs_q[TOP];
  assign mosi_s = mosi_q[TOP];
  assign rise   = !cs_s &&  sclk_q[TOP] && !sclk_d;
  assign fall   = !cs_s && !sclk_q[TOP] &&  sclk_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (cs_s) begin
      cnt <= '0;
    end else if (rise) begin
      sh <= {sh[13:0], mosi_s};
      if (cnt < CW'(FRAME)) cnt <= cnt + 1'b1;
    end

  assign commit = rise && cnt == CW'(FRAME - 1);
  assign wr     = commit && !sh[14];
  assign waddr  = sh[12:7];
  assign wdata  = {sh[6:0], mosi_s};
  assign raddr  = {sh[4:0], mosi_s};
  assign load   = rise && cnt == CW'(HALF - 1) && sh[6];

  assign clr_t = wr && waddr == A_STAT && !wdata[5];
  assign clr_i = wr && waddr == A_STAT && !wdata[6];
  assign srst  = wr && waddr == A_STAT && wdata[4:2] == 3'b101;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      enable1_o <= '0;
      enable2_o <= '0;
      gain_o    <= GAIN_DEF;
      ctrl1_o   <= '0;
      ten       <= 1'b0;
      ien       <= 1'b0;
    end else if (srst) begin
      enable1_o <= '0;
      enable2_o <= '0;
      gain_o    <= GAIN_DEF;
      ten       <= 1'b0;
      ien       <= 1'b0;
    end else if (wr) begin
      case (waddr)
        A_EN1:   enable1_o <= wdata[5:0];
        A_GAIN:  gain_o    <= wdata[5:0];
        A_EN2:   enable2_o <= wdata[3:0];
        A_CTL1:  ctrl1_o   <= wdata;
        A_CTL2:  begin ten <= wdata[5]; ien <= wdata[6]; end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tflag <= 1'b0;
      iflag <= 1'b0;
    end else begin
      tflag <= (ten && therm_evt) || (tflag && !clr_t);
      iflag <= (ien && curr_evt)  || (iflag && !clr_i);
    end

  always_comb
    case (raddr)
      A_EN1:   rd_byte = {2'b00, enable1_o};
      A_GAIN:  rd_byte = {2'b00, gain_o};
      A_EN2:   rd_byte = {4'h0, enable2_o};
      A_CTL1:  rd_byte = ctrl1_o;
      A_CTL2:  rd_byte = {1'b0, ien, ten, 5'b00001};
      A_STAT:  rd_byte = {1'b0, iflag, tflag, 5'b00000};
      A_DIE:   rd_byte = DIE_ID;
      A_REV:   rd_byte = REV_ID;
      default: rd_byte = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         tx <= '0;
    else if (cs_s)                      tx <= '0;
    else if (load)                      tx <= rd_byte;
    else if (fall && cnt > CW'(HALF))   tx <= {tx[6:0], 1'b0};

  assign spi_miso    = tx[7];
  assign spi_miso_oe = !spi_cs_n;

  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_s || fall || load) |=> $stable(spi_miso));
  p_regs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({enable1_o, enable2_o, gain_o, ctrl1_o}));
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ten && therm_evt) |=> tflag);
  p_flag_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tflag && !(ten && therm_evt)) |=> !tflag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iflag && !commit) |=> iflag);
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (enable1_o == 6'h00 && enable2_o == 4'h0 && gain_o == GAIN_DEF && !ten && !ien));
  p_ctrl1_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> $stable(ctrl1_o));
endmodule

// File: tb/sim_spi_regbank.sv
module sim_spi_regbank;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, therm = 1'b0, curr = 1'b0;
  logic miso, miso_oe;
  logic [5:0] en1_o, gain_o;
  logic [3:0] en2_o;
  logic [7:0] c1_o;

  int vectors = 0, miscompares = 0;
  bit quiet = 1'b0;
  logic [7:0] m_en1, m_gain, m_en2, m_c1, m_c2;
  bit m_tf, m_if;
  logic [7:0] q;

  always #(CLK_NS/2) clk = ~clk;

  spi_regbank #(.SYNC_STAGES(3), .DIE_ID(8'hC3)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .therm_evt(therm), .curr_evt(curr),
    .enable1_o(en1_o), .enable2_o(en2_o), .gain_o(gain_o), .ctrl1_o(c1_o));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_defaults();
    m_en1 = 8'h00; m_gain = 8'h32; m_en2 = 8'h00; m_c2 = 8'h01;
  endtask

  function automatic logic [7:0] model_read(input logic [5:0] a);
    case (a)
      6'h01: return m_en1;
      6'h02: return m_gain;
      6'h03: return m_en2;
      6'h04: return m_c1;
      6'h05: return m_c2;
      6'h09: return {1'b0, m_if, m_tf, 5'b0};
      6'h0A: return 8'hC3;
      6'h0B: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    case (a)
      6'h01: m_en1 = d & 8'h3F;
      6'h02: m_gain = d & 8'h3F;
      6'h03: m_en2 = d & 8'h0F;
      6'h04: m_c1 = d;
      6'h05: m_c2 = (d & 8'h60) | 8'h01;
      6'h09: begin
        if (!d[5]) m_tf = 1'b0;
        if (!d[6]) m_if = 1'b0;
        if (d[4:2] == 3'b101) model_defaults();
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) if (rst_n) begin
    if (therm && m_c2[5]) m_tf = 1'b1;
    if (curr  && m_c2[6]) m_if = 1'b1;
  end

  always @(negedge clk) if (rst_n && quiet) begin
    check("R4 enable1_o", en1_o, m_en1[5:0]);
    check("R4 enable2_o", en2_o, m_en2[3:0]);
    check("R4 gain_o",    gain_o, m_gain[5:0]);
    check("R4 ctrl1_o",   c1_o,  m_c1);
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit rd, input logic [6:0] a, input logic [7:0] d,
                      input int nclk, output logic [7:0] r);
    logic [15:0] w;
    w = {rd, a, d};
    r = 8'h00;
    quiet = 1'b0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b0;
      mosi = w[15-i];
      wait_clk(HALF);
      if (i >= 8) r = {r[6:0], miso};
      else if (rd && miso !== 1'b0) check("R2 miso low in first half", miso, 0);
      sclk = 1'b1;
      wait_clk(HALF);
    end
    sclk = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(1'b0, a, d, 16, r);
    model_write(a[5:0], d);
    quiet = 1'b1;
  endtask

  task automatic rd(input string req, input logic [6:0] a);
    logic [7:0] r;
    xfer(1'b1, a, 8'h00, 16, r);
    check(req, r, model_read(a[5:0]));
    quiet = 1'b1;
  endtask

  task automatic pulse(input bit t, input bit c);
    @(negedge clk); therm = t; curr = c;
    @(negedge clk); therm = 1'b0; curr = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    #(CLK_NS * 200000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_defaults();
    m_c1 = 8'h00; m_tf = 1'b0; m_if = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    quiet = 1'b1;
    check("R10 oe idle", miso_oe, 0);
    cs_n = 1'b0; #1;
    check("R10 oe selected", miso_oe, 1);
    cs_n = 1'b1;
    wait_clk(HALF);

    rd("R3 enable1 reset", 7'h01);
    rd("R3 gain reset", 7'h02);
    rd("R3 enable2 reset", 7'h03);
    rd("R3 control1 reset", 7'h04);
    rd("R3 control2 reset", 7'h05);
    rd("R3 status reset", 7'h09);
    rd("R3 die id", 7'h0A);
    rd("R3 revision", 7'h0B);
    rd("R5 unmapped 0x06", 7'h06);
    rd("R5 unmapped 0x3F", 7'h3F);

    wr(7'h01, 8'hFF);  rd("R4 enable1 reserved", 7'h01);
    wr(7'h02, 8'hDB);  rd("R4 gain fields", 7'h02);
    wr(7'h03, 8'hFA);  rd("R4 enable2 reserved", 7'h03);
    wr(7'h04, 8'hA5);  rd("R4 control1", 7'h04);
    wr(7'h01, 8'h2A);  rd("R1 enable1 pattern", 7'h01);
    wr(7'h41, 8'h15);  rd("R1 address bit14 ignored", 7'h01);
    rd("R1 read with bit14", 7'h44);

    wr(7'h0A, 8'h00);  rd("R5 die id write ignored", 7'h0A);
    wr(7'h0B, 8'hFF);  rd("R5 revision write ignored", 7'h0B);
    wr(7'h07, 8'hFF);  rd("R5 unmapped write ignored", 7'h07);

    xfer(1'b0, 7'h01, 8'h3F, 10, q);
    quiet = 1'b1;
    rd("R9 short frame discarded", 7'h01);
    xfer(1'b0, 7'h04, 8'h00, 15, q);
    quiet = 1'b1;
    rd("R9 15-clock frame discarded", 7'h04);

    pulse(1'b1, 1'b1);
    rd("R6 capture disabled", 7'h09);
    wr(7'h05, 8'hFF);  rd("R6 control2 enables", 7'h05);
    pulse(1'b1, 1'b0);
    rd("R6 thermal flag set", 7'h09);
    pulse(1'b0, 1'b1);
    rd("R6 current flag set", 7'h09);
    wr(7'h09, 8'h60);  rd("R7 writing ones keeps flags", 7'h09);
    wr(7'h09, 8'h20);  rd("R7 zero clears current only", 7'h09);
    pulse(1'b0, 1'b0);
    rd("R7 thermal flag latched", 7'h09);
    wr(7'h09, 8'h00);  rd("R7 zero clears thermal", 7'h09);
    wr(7'h05, 8'h20);
    pulse(1'b1, 1'b1);
    rd("R6 only thermal enabled", 7'h09);

    wr(7'h01, 8'h3F); wr(7'h03, 8'h0F); wr(7'h02, 8'h05); wr(7'h04, 8'h5A);
    wr(7'h09, 8'h70);  rd("R8 key 100 no reset", 7'h02);
    wr(7'h09, 8'h34);
    rd("R8 enable1 restored", 7'h01);
    rd("R8 gain restored", 7'h02);
    rd("R8 enable2 restored", 7'h03);
    rd("R8 control2 restored", 7'h05);
    rd("R8 control1 kept", 7'h04);
    rd("R8 flag kept, key bits read zero", 7'h09);
    pulse(1'b1, 1'b1);
    rd("R8 capture disabled after restore", 7'h09);

    wait_clk(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule